// File: doc/BRIEF.md
# First-Error Header Log Queue

This block keeps the error-logging state of an advanced error capability: a five-bit pointer to the first uncorrectable error, a 128-bit captured header, and an optional 128-bit captured prefix. It also owns the 32-bit uncorrectable status register. An error detector upstream presents one error record per cycle. A record carries a one-hot status, four header dwords, four prefix dwords, a header-valid flag and a prefix flag. Software clears status bits through a write-1-to-clear strobe.

When recording of multiple headers is enabled, a later error that arrives while the first is still unacknowledged is held in a small queue. When software clears the status bit that the pointer names, the oldest held record is promoted into the log registers. If the queue is full when a record needs it, the record is dropped and a one-cycle overflow pulse is raised. An error-reporting block elsewhere can turn that pulse into a correctable error.

All state is registered. A record or a status write that arrives on one clock edge is visible on the outputs after that edge. When a write and a record arrive in the same cycle, the write is handled first.

Top module: `hdr_log_queue`

## Requirements
- R1: After reset the status register, both logs, the pointer and the overflow pulse are zero, and the control word reads 0x200 when QDEPTH > 0.
- R2: A record accepted straight into the log sets the pointer (control bits 4:0) to the index of its status bit. Every accepted record sets its bit in the status register.
- R3: A record loaded into the log copies its four header dwords when header-valid is 1. Otherwise the header log becomes zero.
- R4: A record loaded into the log copies its prefix dwords and sets control bit 11 only when both the prefix flag and `pfx_cap` are 1. Otherwise the prefix log is zero and bit 11 is 0.
- R5: When recording is active and the status bit named by the pointer is set, a new record is queued and the log registers keep their contents.
- R6: A record that must be queued while the queue holds QDEPTH entries, with no pop in the same cycle, is discarded, and `log_ovf` is 1 for the following cycle only.
- R7: A write that clears the pointed status bit, with recording active and the queue non-empty, loads the oldest queued record into the log. In the same step it sets again the status bits of every record that was queued.
- R8: A write that clears the pointed status bit while recording is inactive or the queue is empty sets the pointer, control bit 11 and both logs to zero.
- R9: A write that leaves the pointed bit set while recording is inactive empties the queue.
- R10: A record whose status has zero bits set, or more than one, is ignored.
- R11: Control bit 9 is 1 exactly when QDEPTH > 0. Control bit 10 is `mhr_en` AND bit 9. Recording is active when bit 10 is 1.
- R12: When a write and a record arrive in the same cycle, the record is judged against the state that the write leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mhr_en | input | 1 | Software enable for multiple-header recording |
| pfx_cap | input | 1 | Prefix logging supported |
| rec_valid | input | 1 | Error record present this cycle |
| rec_status | input | 32 | One-hot uncorrectable status of the record |
| rec_hdr | input | 128 | Header dwords, dword 0 in bits 31:0 |
| rec_hdr_valid | input | 1 | Header dwords are meaningful |
| rec_pfx | input | 128 | Prefix dwords, dword 0 in bits 31:0 |
| rec_pfx_flag | input | 1 | Record carries prefixes |
| wr_valid | input | 1 | Write-1-to-clear strobe on the status register |
| wr_clr | input | 32 | Bits to clear in the status register |
| ctrl_reg | output | 32 | Pointer [4:0], capable [9], enable [10], prefix present [11] |
| uncor_status | output | 32 | Uncorrectable status register |
| hdr_log | output | 128 | Captured header |
| pfx_log | output | 128 | Captured prefix |
| log_ovf | output | 1 | One-cycle pulse when a record is dropped at a full queue |

## Verification
Directed sequences first cover the direct-capture path: headers with and without the valid flag, and prefixes under each combination of flag and support. These separate the three masking rules. A burst of records then fills the queue and overflows it, and the queue is drained by clearing status bits. This separates in-order promotion and the re-setting of queued status bits from the clear-to-empty path. A sequence that disables recording part-way shows a flushed queue against a retained one, and a combined write-and-record cycle shows the order in which they are handled. Constrained random traffic is biased toward the low status bits and toward clears of the pointed bit. It mixes all of these paths while enable and prefix support toggle, and it is compared against a reference model in the bench.

// File: rtl/hlq_pkg.sv
// Package: shared record type and helpers for the header log queue.
// Assumes 32-bit status words and four-dword header/prefix logs.
package hlq_pkg;
    localparam int STAT_W  = 32;
    localparam int IDX_W   = 5;
    localparam int DWORD_W = 32;
    localparam int LOG_DW  = 4;
    localparam int LOG_W   = DWORD_W * LOG_DW;

    // One pending error record, flags kept so masking happens at load time.
    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [LOG_W-1:0]  hdr;
        logic [LOG_W-1:0]  pfx;
        logic              hdr_ok;
        logic              pfx_ok;
    } hlq_rec_t;

    // Bit index of a one-hot word (lowest set bit).
    function automatic logic [IDX_W-1:0] bit_index(input logic [STAT_W-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = STAT_W - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    // True when exactly one bit is set.
    function automatic logic is_onehot(input logic [STAT_W-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction
endpackage

// File: rtl/hlq_fifo.sv
// Module: ordered store of pending error records (entry 0 is oldest).
// Assumes the caller never pushes when full unless it pops in the same
// cycle, and never pops when empty. Push lands after any same-cycle pop.
module hlq_fifo
    import hlq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              flush,
    input  hlq_rec_t          din,
    output hlq_rec_t          head_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [STAT_W-1:0] status_or_o
);
    hlq_rec_t         mem [DEPTH];
    hlq_rec_t         nxt [DEPTH];
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] wr_idx;

    // Next contents: shift down on pop, then write the pushed record.
    always_comb begin
        wr_idx = count - CNT_W'(pop);
        for (int i = 0; i < DEPTH - 1; i++) begin
            nxt[i] = pop ? mem[i + 1] : mem[i];
        end
        nxt[DEPTH-1] = mem[DEPTH-1];
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (int'(wr_idx) == i) nxt[i] = din;
            end
        end
    end

    // Entry storage and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= nxt[i];
            if (flush) count <= '0;
            else       count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // OR of the status bits of all occupied entries.
    always_comb begin
        status_or_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(count)) status_or_o = status_or_o | mem[i].status;
        end
    end

    assign head_o  = mem[0];
    assign count_o = count;
endmodule

// File: rtl/hlq_log_regs.sv
// Module: first-error pointer, header log, prefix log and prefix-present bit.
// Assumes load and clear are never meant together; load wins if both rise.
module hlq_log_regs
    import hlq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clr,
    input  hlq_rec_t         rec_i,
    input  logic             pfx_cap,
    output logic [IDX_W-1:0] fep_o,
    output logic [LOG_W-1:0] hdr_o,
    output logic [LOG_W-1:0] pfx_o,
    output logic             pfx_present_o
);
    logic pfx_take;

    // Prefixes are captured only when flagged and supported.
    assign pfx_take = rec_i.pfx_ok && pfx_cap;

    // Capture a record, or wipe the log.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fep_o         <= '0;
            hdr_o         <= '0;
            pfx_o         <= '0;
            pfx_present_o <= 1'b0;
        end else if (load) begin
            fep_o         <= bit_index(rec_i.status);
            hdr_o         <= rec_i.hdr_ok ? rec_i.hdr : '0;
            pfx_o         <= pfx_take ? rec_i.pfx : '0;
            pfx_present_o <= pfx_take;
        end else if (clr) begin
            fep_o         <= '0;
            hdr_o         <= '0;
            pfx_o         <= '0;
            pfx_present_o <= 1'b0;
        end
    end
endmodule

// File: rtl/hdr_log_queue.sv
// Module: top of the first-error header log queue. It owns the
// uncorrectable status register and decides, per cycle, whether a software
// clear promotes, clears or flushes, and whether a new record is captured,
// queued or dropped. Assumes QDEPTH is 0..8; the write is evaluated before
// a record in the same cycle.
module hdr_log_queue
    import hlq_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mhr_en,
    input  logic          pfx_cap,
    input  logic          rec_valid,
    input  logic [31:0]   rec_status,
    input  logic [127:0]  rec_hdr,
    input  logic          rec_hdr_valid,
    input  logic [127:0]  rec_pfx,
    input  logic          rec_pfx_flag,
    input  logic          wr_valid,
    input  logic [31:0]   wr_clr,
    output logic [31:0]   ctrl_reg,
    output logic [31:0]   uncor_status,
    output logic [127:0]  hdr_log,
    output logic [127:0]  pfx_log,
    output logic          log_ovf
);
    localparam bit MHR_CAP = (QDEPTH > 0);
    localparam int CNT_W   = $clog2(QDEPTH + 2);

    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] st_after_wr;
    logic [STAT_W-1:0] st_next;
    logic [STAT_W-1:0] q_or;
    logic [CNT_W-1:0]  q_count;
    logic [IDX_W-1:0]  fep;
    logic [IDX_W-1:0]  fep_after_wr;
    logic              pfx_present;
    logic              mhr_act;
    logic              ptr_kept;
    logic              do_pop, do_clr, do_flush, do_reassert;
    logic              rec_ok, rec_queue, do_push, rec_direct, ovf_d;
    logic              q_full;
    logic              log_load;
    hlq_rec_t          rec_in;
    hlq_rec_t          q_head;
    hlq_rec_t          load_rec;

    // Recording is active only if the queue exists and software enabled it.
    assign mhr_act = mhr_en && MHR_CAP;

    // Pack the incoming record.
    assign rec_in = '{status: rec_status, hdr: rec_hdr, pfx: rec_pfx,
                      hdr_ok: rec_hdr_valid, pfx_ok: rec_pfx_flag};

    // Status-write decision: promote, clear or flush.
    always_comb begin
        st_after_wr = wr_valid ? (status_q & ~wr_clr) : status_q;
        ptr_kept    = st_after_wr[fep];
        do_pop      = 1'b0;
        do_clr      = 1'b0;
        do_flush    = 1'b0;
        do_reassert = 1'b0;
        if (wr_valid) begin
            if (!ptr_kept) begin
                if (mhr_act && (q_count != '0)) begin
                    do_pop      = 1'b1;
                    do_reassert = 1'b1;
                end else begin
                    do_clr = 1'b1;
                end
            end else if (mhr_act) begin
                do_reassert = 1'b1;
            end else begin
                do_flush = 1'b1;
            end
        end
        if (do_reassert) st_after_wr = st_after_wr | q_or;
    end

    // Pointer as seen by a record arriving in the same cycle as a write.
    always_comb begin
        if (do_pop)      fep_after_wr = bit_index(q_head.status);
        else if (do_clr) fep_after_wr = '0;
        else             fep_after_wr = fep;
    end

    // Record decision: capture directly, queue, or drop on a full queue.
    assign q_full     = (int'(q_count) >= QDEPTH);
    assign rec_ok     = rec_valid && is_onehot(rec_status);
    assign rec_queue  = rec_ok && mhr_act && st_after_wr[fep_after_wr];
    assign do_push    = rec_queue && (!q_full || do_pop);
    assign ovf_d      = rec_queue && !do_push;
    assign rec_direct = rec_ok && !rec_queue;
    assign st_next    = rec_ok ? (st_after_wr | rec_status) : st_after_wr;

    // Log register source: a direct record, else the promoted queue head.
    assign log_load = rec_direct || do_pop;
    assign load_rec = rec_direct ? rec_in : q_head;

    // Status register and overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            log_ovf  <= 1'b0;
        end else begin
            status_q <= st_next;
            log_ovf  <= ovf_d;
        end
    end

    // Queue present only when a non-zero depth is configured.
    generate
        if (QDEPTH > 0) begin : g_queue
            hlq_fifo #(
                .DEPTH (QDEPTH),
                .CNT_W (CNT_W)
            ) u_fifo (
                .clk         (clk),
                .rst_n       (rst_n),
                .push        (do_push),
                .pop         (do_pop),
                .flush       (do_flush),
                .din         (rec_in),
                .head_o      (q_head),
                .count_o     (q_count),
                .status_or_o (q_or)
            );
        end else begin : g_noqueue
            assign q_head  = '0;
            assign q_count = '0;
            assign q_or    = '0;
        end
    endgenerate

    hlq_log_regs u_log (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (log_load),
        .clr           (do_clr),
        .rec_i         (load_rec),
        .pfx_cap       (pfx_cap),
        .fep_o         (fep),
        .hdr_o         (hdr_log),
        .pfx_o         (pfx_log),
        .pfx_present_o (pfx_present)
    );

    // Control word assembly.
    always_comb begin
        ctrl_reg        = '0;
        ctrl_reg[4:0]   = fep;
        ctrl_reg[9]     = MHR_CAP;
        ctrl_reg[10]    = mhr_act;
        ctrl_reg[11]    = pfx_present;
    end

    assign uncor_status = status_q;
endmodule

// File: rtl/hlq_checker.sv
// Module: temporal checks on the header log queue, bound into the top.
// Assumes it observes the top's ports plus the queue count.
module hlq_checker #(
    parameter int QDEPTH = 4,
    parameter int CNT_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rec_valid,
    input logic             wr_valid,
    input logic [31:0]      rec_status,
    input logic [31:0]      ctrl_reg,
    input logic [31:0]      uncor_status,
    input logic [127:0]     pfx_log,
    input logic             log_ovf,
    input logic [CNT_W-1:0] q_count,
    input logic             mhr_en
);
    // R6
    ovf_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_ovf |-> (int'($past(q_count)) == QDEPTH));

    // R6
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_count) <= QDEPTH);

    // R4
    pfx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_reg[11] |-> (pfx_log == '0));

    // R2
    direct_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && $countones(rec_status) == 1 && !wr_valid && !mhr_en)
        |=> uncor_status[ctrl_reg[4:0]]);

    // R10
    bad_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && $countones(rec_status) != 1 && !wr_valid)
        |=> ($stable(uncor_status) && $stable(ctrl_reg[4:0]) && $stable(ctrl_reg[11])));
endmodule

bind hdr_log_queue hlq_checker #(
    .QDEPTH (QDEPTH),
    .CNT_W  (CNT_W)
) u_hlq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rec_valid    (rec_valid),
    .wr_valid     (wr_valid),
    .rec_status   (rec_status),
    .ctrl_reg     (ctrl_reg),
    .uncor_status (uncor_status),
    .pfx_log      (pfx_log),
    .log_ovf      (log_ovf),
    .q_count      (q_count),
    .mhr_en       (mhr_en)
);

// File: tb/test_hdr_log_queue.sv
// Bench: directed corner cases then seeded random traffic, all compared
// against a reference model written from the requirements.
module test_hdr_log_queue;
    localparam int QD = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mhr_en = 1'b0, pfx_cap = 1'b0;
    logic         rec_valid = 1'b0, rec_hdr_valid = 1'b0, rec_pfx_flag = 1'b0;
    logic [31:0]  rec_status = '0;
    logic [127:0] rec_hdr = '0, rec_pfx = '0;
    logic         wr_valid = 1'b0;
    logic [31:0]  wr_clr = '0;
    logic [31:0]  ctrl_reg, uncor_status;
    logic [127:0] hdr_log, pfx_log;
    logic         log_ovf;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    hdr_log_queue #(.QDEPTH(QD)) i_hdr_log_queue (
        .clk(clk), .rst_n(rst_n), .mhr_en(mhr_en), .pfx_cap(pfx_cap),
        .rec_valid(rec_valid), .rec_status(rec_status), .rec_hdr(rec_hdr),
        .rec_hdr_valid(rec_hdr_valid), .rec_pfx(rec_pfx),
        .rec_pfx_flag(rec_pfx_flag), .wr_valid(wr_valid), .wr_clr(wr_clr),
        .ctrl_reg(ctrl_reg), .uncor_status(uncor_status), .hdr_log(hdr_log),
        .pfx_log(pfx_log), .log_ovf(log_ovf));

    // Reference model state
    logic [31:0]  m_st, m_qs[8];
    logic [127:0] m_hdr, m_pfx, m_qh[8], m_qp[8];
    logic         m_qhv[8], m_qpf[8];
    logic [4:0]   m_fep;
    logic         m_pp, m_ovf;
    int           m_cnt;

    function automatic logic [4:0] idx_of(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return 5'(i);
        return 5'd0;
    endfunction

    task automatic m_reset();
        m_st = '0; m_hdr = '0; m_pfx = '0; m_fep = '0; m_pp = 0; m_ovf = 0; m_cnt = 0;
    endtask

    task automatic m_load(input logic [31:0] s, input logic [127:0] h,
                          input logic hv, input logic [127:0] p, input logic pf);
        m_fep = idx_of(s);
        m_hdr = hv ? h : '0;
        m_pp  = pf && pfx_cap;
        m_pfx = m_pp ? p : '0;
    endtask

    // One clock of the model, using the currently driven inputs.
    task automatic m_step();
        logic [31:0] ws, qor;
        logic act;
        act = mhr_en;
        qor = '0;
        for (int i = 0; i < m_cnt; i++) qor |= m_qs[i];
        ws = m_st;
        m_ovf = 0;
        if (wr_valid) begin
            ws = m_st & ~wr_clr;
            if (!ws[m_fep]) begin
                if (act && m_cnt > 0) begin
                    ws |= qor;
                    m_load(m_qs[0], m_qh[0], m_qhv[0], m_qp[0], m_qpf[0]);
                    for (int i = 0; i < 7; i++) begin
                        m_qs[i] = m_qs[i+1]; m_qh[i] = m_qh[i+1]; m_qp[i] = m_qp[i+1];
                        m_qhv[i] = m_qhv[i+1]; m_qpf[i] = m_qpf[i+1];
                    end
                    m_cnt--;
                end else begin
                    m_fep = '0; m_hdr = '0; m_pfx = '0; m_pp = 0;
                end
            end else if (act) ws |= qor;
            else m_cnt = 0;
        end
        if (rec_valid && $countones(rec_status) == 1) begin
            if (act && ws[m_fep]) begin
                if (m_cnt < QD) begin
                    m_qs[m_cnt] = rec_status; m_qh[m_cnt] = rec_hdr; m_qp[m_cnt] = rec_pfx;
                    m_qhv[m_cnt] = rec_hdr_valid; m_qpf[m_cnt] = rec_pfx_flag;
                    m_cnt++;
                end else m_ovf = 1;
            end else m_load(rec_status, rec_hdr, rec_hdr_valid, rec_pfx, rec_pfx_flag);
            ws |= rec_status;
        end
        m_st = ws;
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic chk_model(input string tag);
        logic [31:0] c;
        c = '0; c[4:0] = m_fep; c[9] = 1'b1; c[10] = mhr_en; c[11] = m_pp;
        chk(tag, "ctrl", 128'(ctrl_reg), 128'(c));
        chk(tag, "status", 128'(uncor_status), 128'(m_st));
        chk(tag, "hdr", hdr_log, m_hdr);
        chk(tag, "pfx", pfx_log, m_pfx);
        chk(tag, "ovf", 128'(log_ovf), 128'(m_ovf));
    endtask

    // Apply one clock with the driven inputs, then compare mid-cycle.
    task automatic step(input string tag);
        @(posedge clk);
        m_step();
        #5;
        chk_model(tag);
        rec_valid = 0; wr_valid = 0; wr_clr = '0;
    endtask

    task automatic rec(input int bitn, input logic hv, input logic pf);
        rec_valid = 1; rec_status = 32'd1 << bitn;
        rec_hdr = {$urandom, $urandom, $urandom, $urandom}; rec_hdr_valid = hv;
        rec_pfx = {$urandom, $urandom, $urandom, $urandom}; rec_pfx_flag = pf;
    endtask

    task automatic wr(input logic [31:0] d);
        wr_valid = 1; wr_clr = d;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(20 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_reset();
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        #3;
        // R1 reset values
        chk("R1", "ctrl", 128'(ctrl_reg), 128'(32'h200));
        chk("R1", "status", 128'(uncor_status), 128'd0);
        chk("R1", "logs", hdr_log | pfx_log, 128'd0);
        chk("R1", "ovf", 128'(log_ovf), 128'd0);

        // R11 enable bit follows mhr_en
        mhr_en = 1; #1;
        chk("R11", "ctrl", 128'(ctrl_reg), 128'(32'h600));
        mhr_en = 0;

        // R2 R3 R4 direct capture with header and prefix
        pfx_cap = 1; rec(5, 1, 1); step("R2");
        chk("R2", "fep", 128'(ctrl_reg[4:0]), 128'd5);
        chk("R4", "pp", 128'(ctrl_reg[11]), 128'd1);
        // R3 R4 overwrite with no header and no prefix support
        pfx_cap = 0; rec(7, 0, 1); step("R3");
        chk("R3", "hdr", hdr_log, 128'd0);
        chk("R4", "pfx", pfx_log, 128'd0);
        pfx_cap = 1;

        // R5 queue four records behind pointer 7, R6 fifth overflows
        mhr_en = 1;
        for (int b = 1; b <= 4; b++) begin rec(b, 1, b[0]); step("R5"); end
        chk("R5", "fep", 128'(ctrl_reg[4:0]), 128'd7);
        rec(6, 1, 0); step("R6");
        chk("R6", "ovf", 128'(log_ovf), 128'd1);
        step("R6");
        chk("R6", "ovf-pulse", 128'(log_ovf), 128'd0);

        // R7 clear bits 1..4 and pointer: oldest (bit 1) promoted, bits re-set
        wr(32'h9E); step("R7");
        chk("R7", "fep", 128'(ctrl_reg[4:0]), 128'd1);
        chk("R7", "status", 128'(uncor_status & 32'h1E), 128'(32'h1E));
        for (int b = 1; b <= 4; b++) begin wr(32'd1 << b); step("R7"); end
        // R8 queue empty, pointer cleared
        chk("R8", "fep", 128'(ctrl_reg[4:0]), 128'd0);
        chk("R8", "hdr", hdr_log, 128'd0);

        // R9 flush when disabled and pointer still set
        wr(32'hFFFF_FFFF); step("R8");
        rec(8, 1, 1); step("R9");
        rec(9, 1, 1); step("R9");
        mhr_en = 0; wr(32'h200); step("R9");
        mhr_en = 1; wr(32'h100); step("R9");
        chk("R9", "hdr", hdr_log, 128'd0);
        chk("R9", "fep", 128'(ctrl_reg[4:0]), 128'd0);

        // R10 invalid statuses
        rec(3, 1, 1); step("R10");
        rec_valid = 1; rec_status = 32'h0000_0006; step("R10");
        rec_valid = 1; rec_status = 32'h0; step("R10");
        chk("R10", "fep", 128'(ctrl_reg[4:0]), 128'd3);

        // R12 same-cycle write of the pointer and a new record
        rec(11, 1, 0); wr(32'h8); step("R12");
        chk("R12", "fep", 128'(ctrl_reg[4:0]), 128'd11);

        // Random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            if ($urandom % 50 == 0) mhr_en = ~mhr_en;
            if ($urandom % 40 == 0) pfx_cap = ~pfx_cap;
            if ($urandom % 3 == 0) begin
                rec($urandom % 8, 1'($urandom), 1'($urandom));
                if ($urandom % 12 == 0) rec_status = $urandom & 32'hFF;
            end
            if ($urandom % 4 == 0)
                wr(($urandom % 2 == 0) ? (32'd1 << m_fep) : ($urandom & 32'hFF));
            step("R12-model");
        end

        summary();
        $finish;
    end
endmodule